// File: doc/BRIEF.md
# Chroma Transient Improvement Engine

This block sharpens colour edges in a chroma stream that arrives at a quarter of the luma sample rate. A pixel strobe marks every luma sample; on every fourth strobe the block takes one U and one V sample. It rebuilds a full-rate chroma stream by two rounds of 2:1 linear interpolation, so each interpolated sample is the rounded mean of its neighbours. It then reads that stream through a variable delay. Near an edge the read point is first pushed later (an older sample is held) and then pulled earlier (a newer sample is fetched), so a soft ramp becomes a short, steep step.

The read offset is steered by a signed measure built from the second differences of U and V. It is scaled by a selectable gain and limited to a selectable range. An optional guard finds local peaks and valleys in either channel and stops the read point from moving past them. This keeps two close edges from bleeding into each other. One U/V pair leaves the block for every pixel strobe, with a valid flag.

Top module: `cti_engine`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0 and `out_u`/`out_v` are 0.
- R2: Each cycle with `pix_en` high gives exactly one cycle of `out_valid` two clocks later. `out_u`/`out_v` change only in cycles where `out_valid` is high.
- R3: Strobes are counted from reset starting at 0. Chroma inputs are read only on strobes whose count is a multiple of four. Values present on other strobes have no effect on the output.
- R4: Take input samples c[m] as two's-complement, with c[-1]=0, and avg(x,y)=floor((x+y+1)/2). Let a=c[m-1], b=c[m] and h=avg(a,b). Interpolated sample f[4m+p] is a, avg(a,h), h, avg(h,b) for p=0,1,2,3. With gain code 0, the output on strobe k is f[k-13], that is f[k-1-MAX_RANGE], taking f of a negative index as 0.
- R5: The centre is n=k-1-MAX_RANGE. Per channel, d2=f[n-2]+f[n+2]-2f[n] and d1=f[n+2]-f[n-2]. The steering value t is the sum over U and V of sign(d1)·d2. The offset magnitude is |t|>>(STEER_SHIFT+3-g) for gain code g of 1, 2 or 3 (gain 1/4, 1/2, 1), and 0 for g=0.
- R6: Range codes 0, 1, 2 and 3 clamp the offset magnitude to 12, 8, 6 and 4 pixels, never beyond MAX_RANGE.
- R7: The output is f[n-o] with signed offset o. o is +magnitude when t>0 (older sample, delay above nominal), -magnitude when t<0, and 0 when t=0.
- R8: With `guard_en`=1, a sample is marked when it is a strict local maximum or minimum of U or of V. The offset is cut to the distance to the nearest marked sample in its own direction, looking at distances 0 to MAX_RANGE-1. A marked centre gives offset 0.
- R9: With `guard_en`=0 the offset is not limited by marked samples.
- R10: A single triangular chroma pulse with gain 1, range 12 and the guard on gives a U output that never decreases before its maximum and never increases after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel strobe, one per luma sample |
| chroma_u | input | CW | U sample, two's complement |
| chroma_v | input | CW | V sample, two's complement |
| gain_sel | input | 2 | Gain code: 0, 1/4, 1/2, 1 |
| range_sel | input | 2 | Range code: 12, 8, 6, 4 pixels |
| guard_en | input | 1 | Enable extremum guard |
| out_valid | output | 1 | Output sample strobe |
| out_u | output | CW | Sharpened full-rate U |
| out_v | output | CW | Sharpened full-rate V |

## Verification
Random chroma with gain 0 and gapped strobes shows that plain interpolation, the fixed latency and the four-strobe sampling are right. Garbage is placed on the ignored strobes. A U/V step with gain 1 and the smallest range shows the delay sign: the intermediate ramp values must vanish from the output. A narrow triangular pulse is run once with the guard on and once with it off. Only the guarded run may stay monotonic on both flanks, so this pattern separates a working guard from a missing one. Random runs over all gain, range and guard codes then cover the scaling and clamping.

// File: rtl/cti_pkg.sv
package cti_pkg;

  typedef enum logic [1:0] {
    GAIN_ZERO    = 2'd0,
    GAIN_QUARTER = 2'd1,
    GAIN_HALF    = 2'd2,
    GAIN_FULL    = 2'd3
  } gain_code_e;

  // Offset limit in pixels for each range code.
  function automatic int range_px(input logic [1:0] code);
    case (code)
      2'd0:    return 12;
      2'd1:    return 8;
      2'd2:    return 6;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cti_upsampler.sv
module cti_upsampler #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic signed [CW-1:0] in_u,
  input  logic signed [CW-1:0] in_v,
  output logic signed [CW-1:0] f_u,
  output logic signed [CW-1:0] f_v,
  output logic                 f_en
);

  logic [1:0] phase, phase_n;
  logic signed [CW-1:0] a_u, b_u, a_v, b_v;
  logic signed [CW-1:0] a_u_n, b_u_n, a_v_n, b_v_n, f_u_n, f_v_n;
  logic load;

  function automatic logic signed [CW-1:0] ravg(input logic signed [CW-1:0] x,
                                                input logic signed [CW-1:0] y);
    logic signed [CW:0] s;
    s = {x[CW-1], x} + {y[CW-1], y} + {{CW{1'b0}}, 1'b1};
    return s[CW:1];
  endfunction

  function automatic logic signed [CW-1:0] pick(input logic signed [CW-1:0] a,
                                                input logic signed [CW-1:0] b,
                                                input logic [1:0] ph);
    logic signed [CW-1:0] h;
    h = ravg(a, b);
    case (ph)
      2'd0:    return a;
      2'd1:    return ravg(a, h);
      2'd2:    return h;
      default: return ravg(h, b);
    endcase
  endfunction

  always_comb begin
    load    = pix_en && (phase == 2'd0);
    a_u_n   = load ? b_u  : a_u;
    b_u_n   = load ? in_u : b_u;
    a_v_n   = load ? b_v  : a_v;
    b_v_n   = load ? in_v : b_v;
    phase_n = pix_en ? phase + 2'd1 : phase;
    f_u_n   = pix_en ? pick(a_u_n, b_u_n, phase) : f_u;
    f_v_n   = pix_en ? pick(a_v_n, b_v_n, phase) : f_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      a_u   <= '0;
      b_u   <= '0;
      a_v   <= '0;
      b_v   <= '0;
      f_u   <= '0;
      f_v   <= '0;
      f_en  <= 1'b0;
    end else begin
      phase <= phase_n;
      a_u   <= a_u_n;
      b_u   <= b_u_n;
      a_v   <= a_v_n;
      b_v   <= b_v_n;
      f_u   <= f_u_n;
      f_v   <= f_v_n;
      f_en  <= pix_en;
    end
  end

endmodule

// File: rtl/cti_delay_line.sv
module cti_delay_line #(
  parameter int CW    = 8,
  parameter int DEPTH = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [CW-1:0] in_u,
  input  logic signed [CW-1:0] in_v,
  output logic signed [CW-1:0] tap_u [DEPTH],
  output logic signed [CW-1:0] tap_v [DEPTH]
);

  // Tap 0 holds the newest sample, tap DEPTH-1 the oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic signed [CW-1:0] src_u, src_v;
    if (i == 0) begin : g_head
      assign src_u = in_u;
      assign src_v = in_v;
    end else begin : g_body
      assign src_u = tap_u[i-1];
      assign src_v = tap_v[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_u[i] <= '0;
        tap_v[i] <= '0;
      end else if (shift_en) begin
        tap_u[i] <= src_u;
        tap_v[i] <= src_v;
      end
    end
  end

endmodule

// File: rtl/cti_extrema.sv
module cti_extrema #(
  parameter int CW    = 8,
  parameter int DEPTH = 25
) (
  input  logic signed [CW-1:0] tap_u [DEPTH],
  input  logic signed [CW-1:0] tap_v [DEPTH],
  output logic [DEPTH-1:0]     mark
);

  // A tap is marked when the slope changes sign strictly across it.
  for (genvar j = 0; j < DEPTH; j++) begin : g_mark
    if (j == 0 || j == DEPTH - 1) begin : g_edge
      assign mark[j] = 1'b0;
    end else begin : g_inner
      logic pk_u, pk_v;
      assign pk_u = ((tap_u[j-1] > tap_u[j]) && (tap_u[j+1] > tap_u[j])) ||
                    ((tap_u[j-1] < tap_u[j]) && (tap_u[j+1] < tap_u[j]));
      assign pk_v = ((tap_v[j-1] > tap_v[j]) && (tap_v[j+1] > tap_v[j])) ||
                    ((tap_v[j-1] < tap_v[j]) && (tap_v[j+1] < tap_v[j]));
      assign mark[j] = pk_u || pk_v;
    end
  end

endmodule

// File: rtl/cti_steer.sv
module cti_steer #(
  parameter int CW          = 8,
  parameter int MAX_RANGE   = 12,
  parameter int STEER_SHIFT = 2,
  parameter int OW          = 5,
  localparam int DEPTH      = 2 * MAX_RANGE + 1,
  localparam int DW         = CW + 3,
  localparam int TW         = CW + 4
) (
  input  logic signed [CW-1:0] tap_u [DEPTH],
  input  logic signed [CW-1:0] tap_v [DEPTH],
  input  logic [DEPTH-1:0]     mark,
  input  logic [1:0]           gain_sel,
  input  logic [1:0]           range_sel,
  input  logic                 guard_en,
  output logic signed [OW-1:0] offset
);

  localparam int C = MAX_RANGE;

  function automatic logic signed [DW-1:0] sx(input logic signed [CW-1:0] x);
    return {{(DW-CW){x[CW-1]}}, x};
  endfunction

  // Second difference signed by the local slope direction.
  function automatic logic signed [TW-1:0] steer_term(input logic signed [CW-1:0] older,
                                                      input logic signed [CW-1:0] ctr,
                                                      input logic signed [CW-1:0] newer);
    logic signed [DW-1:0] d1, d2;
    logic signed [TW-1:0] e;
    d2 = sx(older) + sx(newer) - (sx(ctr) <<< 1);
    d1 = sx(newer) - sx(older);
    e  = {d2[DW-1], d2};
    if (d1 == '0)     return '0;
    else if (d1[DW-1]) return -e;
    else               return e;
  endfunction

  logic signed [TW-1:0] t_sum;
  logic [TW-1:0]        t_mag;

  always_comb begin
    int scaled, rng, amt, lim_old, lim_new;
    t_sum = steer_term(tap_u[C+2], tap_u[C], tap_u[C-2]) +
            steer_term(tap_v[C+2], tap_v[C], tap_v[C-2]);
    t_mag = t_sum[TW-1] ? -t_sum : t_sum;

    if (gain_sel == 2'd0) scaled = 0;
    else                  scaled = int'(t_mag >> (STEER_SHIFT + 3 - int'(gain_sel)));

    rng = cti_pkg::range_px(range_sel);
    if (rng > C) rng = C;
    amt = (scaled > rng) ? rng : scaled;

    lim_old = C;
    lim_new = C;
    for (int j = C - 1; j >= 0; j--) begin
      if (mark[C+j]) lim_old = j;
      if (mark[C-j]) lim_new = j;
    end

    if (guard_en) begin
      if (!t_sum[TW-1] && amt > lim_old) amt = lim_old;
      if (t_sum[TW-1]  && amt > lim_new) amt = lim_new;
    end

    if (t_sum == '0)      offset = '0;
    else if (t_sum[TW-1]) offset = OW'(-amt);
    else                  offset = OW'(amt);
  end

endmodule

// File: rtl/cti_engine.sv
module cti_engine #(
  parameter int CW          = 8,
  parameter int MAX_RANGE   = 12,
  parameter int STEER_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [CW-1:0] chroma_u,
  input  logic [CW-1:0] chroma_v,
  input  logic [1:0]    gain_sel,
  input  logic [1:0]    range_sel,
  input  logic          guard_en,
  output logic          out_valid,
  output logic [CW-1:0] out_u,
  output logic [CW-1:0] out_v
);

  localparam int DEPTH = 2 * MAX_RANGE + 1;
  localparam int OW    = $clog2(MAX_RANGE + 1) + 1;

  logic signed [CW-1:0] f_u, f_v;
  logic                 f_en;
  logic signed [CW-1:0] tap_u [DEPTH];
  logic signed [CW-1:0] tap_v [DEPTH];
  logic [DEPTH-1:0]     mark_vec;
  logic signed [OW-1:0] steer_off;
  logic signed [CW-1:0] sel_u, sel_v;
  logic [CW-1:0]        out_u_n, out_v_n;

  cti_upsampler #(.CW(CW)) u_ups (
    .clk   (clk),
    .rst_n (rst_n),
    .pix_en(pix_en),
    .in_u  ($signed(chroma_u)),
    .in_v  ($signed(chroma_v)),
    .f_u   (f_u),
    .f_v   (f_v),
    .f_en  (f_en)
  );

  cti_delay_line #(.CW(CW), .DEPTH(DEPTH)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(f_en),
    .in_u    (f_u),
    .in_v    (f_v),
    .tap_u   (tap_u),
    .tap_v   (tap_v)
  );

  cti_extrema #(.CW(CW), .DEPTH(DEPTH)) u_ext (
    .tap_u(tap_u),
    .tap_v(tap_v),
    .mark (mark_vec)
  );

  cti_steer #(.CW(CW), .MAX_RANGE(MAX_RANGE), .STEER_SHIFT(STEER_SHIFT), .OW(OW)) u_steer (
    .tap_u    (tap_u),
    .tap_v    (tap_v),
    .mark     (mark_vec),
    .gain_sel (gain_sel),
    .range_sel(range_sel),
    .guard_en (guard_en),
    .offset   (steer_off)
  );

  // Read point: centre tap moved by the steering offset.
  always_comb begin
    sel_u = tap_u[MAX_RANGE];
    sel_v = tap_v[MAX_RANGE];
    for (int i = 0; i < DEPTH; i++) begin
      if (i == MAX_RANGE + int'(steer_off)) begin
        sel_u = tap_u[i];
        sel_v = tap_v[i];
      end
    end
    out_u_n = f_en ? sel_u : out_u;
    out_v_n = f_en ? sel_v : out_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_u     <= '0;
      out_v     <= '0;
    end else begin
      out_valid <= f_en;
      out_u     <= out_u_n;
      out_v     <= out_v_n;
    end
  end

endmodule

// File: rtl/cti_engine_chk.sv
module cti_engine_chk #(
  parameter int CW        = 8,
  parameter int MAX_RANGE = 12,
  parameter int OW        = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_en,
  input logic                 out_valid,
  input logic [CW-1:0]        out_u,
  input logic [CW-1:0]        out_v,
  input logic [1:0]           gain_sel,
  input logic [1:0]           range_sel,
  input logic                 guard_en,
  input logic signed [OW-1:0] steer_off,
  input logic                 ctr_mark
);

  // R2
  valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |-> ##2 out_valid);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_u) && $stable(out_v)));

  // R5
  gain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_sel == 2'd0) |-> (steer_off == '0));

  // R6
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(steer_off) <= cti_pkg::range_px(range_sel)) &&
    (int'(steer_off) >= -cti_pkg::range_px(range_sel)) &&
    (int'(steer_off) <= MAX_RANGE) && (int'(steer_off) >= -MAX_RANGE));

  // R8
  peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_en && ctr_mark) |-> (steer_off == '0));

endmodule

bind cti_engine cti_engine_chk #(
  .CW(CW), .MAX_RANGE(MAX_RANGE), .OW($clog2(MAX_RANGE + 1) + 1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_en   (pix_en),
  .out_valid(out_valid),
  .out_u    (out_u),
  .out_v    (out_v),
  .gain_sel (gain_sel),
  .range_sel(range_sel),
  .guard_en (guard_en),
  .steer_off(steer_off),
  .ctr_mark (mark_vec[MAX_RANGE])
);

// File: tb/tb_cti_engine.sv
module tb_cti_engine;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int R  = 12;
  localparam int SH = 2;

  logic clk, rst_n, pix_en, guard_en, out_valid;
  logic [CW-1:0] chroma_u, chroma_v, out_u, out_v;
  logic [1:0] gain_sel, range_sel;

  int cu [128];
  int cv [128];
  int ou [1024];
  int kout, checks, fails, mon_on, done;
  string tag;

  cti_engine #(.CW(CW), .MAX_RANGE(R), .STEER_SHIFT(SH)) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .chroma_u(chroma_u), .chroma_v(chroma_v),
    .gain_sel(gain_sel), .range_sel(range_sel), .guard_en(guard_en),
    .out_valid(out_valid), .out_u(out_u), .out_v(out_v)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ravg(int x, int y);
    return (x + y + 1) >>> 1;
  endfunction

  // Interpolated full-rate sample per R4.
  function automatic int fs(int ch, int k);
    int m, p, a, b, h;
    if (k < 0) return 0;
    m = k / 4; p = k % 4;
    a = (m == 0) ? 0 : ((ch == 0) ? cu[m-1] : cv[m-1]);
    b = (ch == 0) ? cu[m] : cv[m];
    h = ravg(a, b);
    case (p)
      0: return a;
      1: return ravg(a, h);
      2: return h;
      default: return ravg(h, b);
    endcase
  endfunction

  function automatic bit is_ext(int j);
    for (int ch = 0; ch < 2; ch++) begin
      int a, b, c;
      a = fs(ch, j-1); b = fs(ch, j); c = fs(ch, j+1);
      if ((a > b && c > b) || (a < b && c < b)) return 1;
    end
    return 0;
  endfunction

  function automatic int rng_of(int code);
    case (code) 0: return 12; 1: return 8; 2: return 6; default: return 4; endcase
  endfunction

  // Expected output for centre n per R5..R9.
  function automatic int model(int ch, int n);
    int t, mag, amt, rng, lim, off;
    t = 0;
    for (int c = 0; c < 2; c++) begin
      int d1, d2;
      d2 = fs(c, n-2) + fs(c, n+2) - 2 * fs(c, n);
      d1 = fs(c, n+2) - fs(c, n-2);
      if (d1 > 0) t += d2; else if (d1 < 0) t -= d2;
    end
    mag = (t < 0) ? -t : t;
    amt = (gain_sel == 2'd0) ? 0 : (mag >> (SH + 3 - int'(gain_sel)));
    rng = rng_of(int'(range_sel));
    if (amt > rng) amt = rng;
    if (guard_en) begin
      lim = R;
      for (int j = R - 1; j >= 0; j--)
        if (is_ext((t > 0) ? n - j : n + j)) lim = j;
      if (amt > lim) amt = lim;
    end
    off = (t > 0) ? amt : ((t < 0) ? -amt : 0);
    return fs(ch, n - off);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && mon_on != 0) begin
      int n, eu, ev;
      n  = kout - 1 - R;
      eu = model(0, n);
      ev = model(1, n);
      check(int'($signed(out_u)) == eu, {tag, " U"}, int'($signed(out_u)), eu);
      check(int'($signed(out_v)) == ev, {tag, " V"}, int'($signed(out_v)), ev);
      ou[kout] = int'($signed(out_u));
      kout++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(int n, bit gaps, string t);
    int total;
    tag = t;
    do_reset();
    kout = 0;
    mon_on = 1;
    total = 4 * n + R + 8;
    for (int k = 0; k < total; k++) begin
      @(negedge clk);
      pix_en = 1'b1;
      // R3: non-sampling strobes carry garbage
      chroma_u = (k % 4 == 0) ? CW'(cu[k/4]) : CW'($urandom);
      chroma_v = (k % 4 == 0) ? CW'(cv[k/4]) : CW'($urandom);
      if (gaps) begin
        int idle;
        idle = int'($urandom % 3);
        for (int i = 0; i < idle; i++) begin
          @(negedge clk);
          pix_en = 1'b0;
          chroma_u = CW'($urandom);
        end
      end
    end
    @(negedge clk);
    pix_en = 1'b0;
    repeat (4) @(negedge clk);
    mon_on = 0;
    // R2: one output per strobe
    check(kout == total, "R2 output count", kout, total);
  endtask

  function automatic bit monotonic(int len);
    int imax;
    imax = 0;
    for (int i = 1; i < len; i++) if (ou[i] > ou[imax]) imax = i;
    for (int i = 0; i < imax; i++) if (ou[i] > ou[i+1]) return 0;
    for (int i = imax; i < len - 1; i++) if (ou[i] < ou[i+1]) return 0;
    return 1;
  endfunction

  task automatic clear_src();
    for (int i = 0; i < 128; i++) begin cu[i] = 0; cv[i] = 0; end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    checks = 0; fails = 0; done = 0; mon_on = 0; kout = 0;
    rst_n = 1'b0; pix_en = 1'b0; chroma_u = '0; chroma_v = '0;
    gain_sel = 2'd0; range_sel = 2'd0; guard_en = 1'b0;
    tag = "";
    repeat (2) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    check(out_u == '0 && out_v == '0, "R1 data", int'(out_u), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_u == '0, "R1 after release", int'(out_valid), 0);

    // R3 R4: plain interpolation, gapped strobes
    clear_src();
    for (int i = 0; i < 40; i++) begin cu[i] = $signed(CW'($urandom)); cv[i] = $signed(CW'($urandom)); end
    gain_sel = 2'd0; range_sel = 2'd0; guard_en = 1'b1;
    run_case(40, 1'b1, "R3 R4 interp");

    // R5 R7: step, full gain, smallest range
    clear_src();
    for (int i = 4; i < 128; i++) begin cu[i] = 100; cv[i] = 0; end
    gain_sel = 2'd3; range_sel = 2'd3; guard_en = 1'b0;
    run_case(12, 1'b0, "R5 R7 step");
    begin
      int ramp;
      ramp = 0;
      for (int i = 0; i < kout; i++) if (ou[i] == 25 || ou[i] == 75) ramp++;
      check(ramp == 0, "R7 ramp removed", ramp, 0);
    end

    // R8 R10: hill with guard on
    clear_src();
    cu[5] = 80; cv[5] = -60;
    gain_sel = 2'd3; range_sel = 2'd0; guard_en = 1'b1;
    run_case(10, 1'b0, "R8 hill");
    check(monotonic(kout) == 1, "R10 monotonic flanks", 0, 1);

    // R9: same hill, guard off gives a dip
    guard_en = 1'b0;
    run_case(10, 1'b0, "R9 hill");
    check(monotonic(kout) == 0, "R9 unguarded dip", 1, 0);

    // R5 R6: random controls and data
    for (int r = 0; r < 8; r++) begin
      clear_src();
      for (int i = 0; i < 30; i++) begin
        cu[i] = ($urandom % 2) ? $signed(CW'($urandom)) : ((i % 6 < 3) ? -90 : 90);
        cv[i] = $signed(CW'($urandom % 64)) - 32;
      end
      gain_sel  = 2'($urandom);
      range_sel = 2'(r % 4);
      guard_en  = 1'($urandom);
      run_case(30, r[0], "R5 R6 random");
    end

    finish_run();
  end

endmodule